// File: doc/BRIEF.md
# Line sensor readout timing controller

This block sits on the host side of a two-section linear photodiode array. From the system clock it generates the sensor clock, a start pulse and a hold pulse for each section, and a sample strobe for an external analog-to-digital converter. The strobe carries a pixel index and a section tag. Two quantities are programmable: the sensor clock half-period, in system cycles, and the start-to-start period, in sensor clocks. The integration time that the sensor sees is the start-to-start period minus the 18 clocks of its internal reset.

There are two scan modes. In serial mode section A's serial output is wired on the board to section B's start input, so one start pulse reads both sections as one chain. That scan needs 2·PIX+1 sensor clocks, and the last clock only ends the final serial-out pulse. In parallel mode both sections get the start and hold pulses together and are read at the same time, in PIX+1 clocks.

Three limits are enforced. Too short a half-period is raised to a floor that keeps each clock phase at 50 ns or more. Too short a period is raised to the scan length. The strobe is placed a fixed settling delay after each rising edge, so the converter samples a settled output.

Top module: `linescan_timing_ctrl`

## Requirements
- R1: Each high phase and each low phase of `sclk` lasts exactly max(`cfg_half`, MIN_HALF) system cycles. `sclk` is low while `en` is low.
- R2: `si_a` rises in the same cycle in which `sclk` falls. It stays high for 2·max(`cfg_half`, MIN_HALF) cycles, so exactly one rising edge of `sclk` samples it. `hold_a` equals `si_a` at all times.
- R3: `hold_b` equals `si_a` at all times. `si_b` equals `si_a` during a parallel scan and stays low during a serial scan.
- R4: `busy` rises together with `si_a`. The scan length L is 2·PIX+1 when serial (`cfg_parallel`=0) and PIX+1 when parallel (`cfg_parallel`=1). Counting the sampling edge as edge 1, `line_done` is a one-cycle pulse in the first high cycle of edge L. `busy` is low in that cycle.
- R5: Consecutive sampling edges of the start pulse are exactly max(`cfg_period`, L) rising edges of `sclk` apart.
- R6: `pix_valid` is a one-cycle pulse exactly SETTLE cycles after the first high cycle of `sclk` for each of edges 1 to L-1, and for no other edge. Each scan therefore gives L-1 strobes.
- R7: At edge e, `pix_idx` is e-1. In a serial scan `pix_sect` is 2'b01 (bit 0 = section A) while the index is below PIX, and 2'b10 (bit 1 = section B) from PIX on. In a parallel scan `pix_sect` is 2'b11 and the index stays below PIX.
- R8: `cfg_parallel` and `cfg_period` are captured when `si_a` rises. Changing them during a scan does not alter that scan's length, routing or period.
- R9: In reset, and from the first clock edge at which `en` is sampled low, `sclk`, `si_a`, `si_b`, `busy`, `line_done` and `pix_valid` are all low. Any scan in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops the clock and abandons a scan |
| cfg_parallel | input | 1 | 0 = serial chained scan, 1 = both sections in parallel |
| cfg_half | input | HALF_W | Sensor clock half-period in system cycles |
| cfg_period | input | PER_W | Start-to-start period in sensor clocks |
| sclk | output | 1 | Sensor clock to both sections |
| si_a | output | 1 | Start pulse, section A |
| hold_a | output | 1 | Hold pulse, section A |
| si_b | output | 1 | Start pulse, section B (parallel scans only) |
| hold_b | output | 1 | Hold pulse, section B |
| busy | output | 1 | High while a scan is being clocked out |
| line_done | output | 1 | One-cycle pulse at the terminating clock |
| pix_valid | output | 1 | Sample strobe for the converter |
| pix_idx | output | IDX_W | Index of the pixel being strobed |
| pix_sect | output | 2 | Sections whose output is valid (bit 0 = A, bit 1 = B) |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a scan. The captured values must govern that scan to its end, and the new values must apply only from the next start pulse. The stimulus waits for `busy` to rise and then flips the mode and shortens the period two cycles later. It then checks that the scan ends at the old length and that the following scan follows the new one. The bench also has to catch the boundary where the programmed period is at or below the scan length, with the next start falling right after the terminating edge. Directed cases with a period of zero reach that boundary, and seeded random half-periods, modes and periods around the scan length add more cases.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/lsc_sclk_gen.sv
// Sensor clock divider: free-running while enabled, phase length clamped.
module lsc_sclk_gen #(
  parameter int HALF_W   = 8,
  parameter int MIN_HALF = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] cfg_half,
  output logic              sclk,
  output logic              rise_evt,
  output logic              fall_evt
);
  localparam logic [HALF_W-1:0] HALF_FLOOR = HALF_W'(MIN_HALF);

  logic [HALF_W-1:0] half_eff;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              sclk_q, sclk_d;
  logic              tick;

  always_comb begin
    half_eff = (cfg_half < HALF_FLOOR) ? HALF_FLOOR : cfg_half;
    tick     = en && (cnt_q >= (half_eff - HALF_W'(1)));
    rise_evt = tick && !sclk_q;
    fall_evt = tick &&  sclk_q;
  end

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  AST_SCLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk_q); // R1
endmodule

// File: rtl/lsc_scan_seq.sv
// Start/hold generation, edge counting, period timer and scan end.
module lsc_scan_seq
  import lsc_pkg::*;
#(
  parameter int PIX   = 768,
  parameter int PER_W = 20,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  scan_mode_e       cfg_mode,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             sclk,
  input  logic             rise_evt,
  input  logic             fall_evt,
  output logic             si,
  output logic             busy,
  output logic             done,
  output scan_mode_e       mode,
  output logic             pix_evt,
  output logic [IDX_W-1:0] pix_num
);
  localparam logic [PER_W-1:0] SER_LEN = PER_W'(2 * PIX + 1);
  localparam logic [PER_W-1:0] PAR_LEN = PER_W'(PIX + 1);
  localparam logic [PER_W-1:0] ONE     = PER_W'(1);

  logic             si_q, si_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             started_q, started_d;
  logic [PER_W-1:0] edge_q, edge_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] len_q, len_d;
  scan_mode_e       mode_q, mode_d;

  logic [PER_W-1:0] len_sel, per_sel;
  logic             due;

  always_comb begin
    len_sel = (cfg_mode == MODE_PARALLEL) ? PAR_LEN : SER_LEN;
    per_sel = (cfg_period < len_sel) ? len_sel : cfg_period;
    due     = !started_q || (edge_q >= per_q);
  end

  always_comb begin
    si_d      = si_q;
    busy_d    = busy_q;
    done_d    = 1'b0;
    started_d = started_q;
    edge_d    = edge_q;
    per_d     = per_q;
    len_d     = len_q;
    mode_d    = mode_q;
    if (!en) begin
      si_d      = 1'b0;
      busy_d    = 1'b0;
      started_d = 1'b0;
      edge_d    = '0;
    end else begin
      if (fall_evt) begin
        if (si_q) begin
          si_d = 1'b0;
        end else if (due) begin
          si_d      = 1'b1;
          busy_d    = 1'b1;
          started_d = 1'b1;
          mode_d    = cfg_mode;
          per_d     = per_sel;
          len_d     = len_sel;
        end
      end
      if (rise_evt) begin
        if (si_q) begin
          edge_d = ONE;
        end else begin
          if (edge_q != '1) edge_d = edge_q + ONE;
          if (busy_q && (edge_q + ONE == len_q)) begin
            done_d = 1'b1;
            busy_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      started_q <= 1'b0;
      edge_q    <= '0;
      per_q     <= SER_LEN;
      len_q     <= SER_LEN;
      mode_q    <= MODE_SERIAL;
    end else begin
      si_q      <= si_d;
      busy_q    <= busy_d;
      done_q    <= done_d;
      started_q <= started_d;
      edge_q    <= edge_d;
      per_q     <= per_d;
      len_q     <= len_d;
      mode_q    <= mode_d;
    end
  end

  // a pixel appears on the output after every edge from the sampling edge
  // up to, but not including, the terminating edge
  always_comb begin
    pix_evt = en && rise_evt && (si_q || (busy_q && (edge_q + ONE < len_q)));
    pix_num = si_q ? '0 : edge_q[IDX_W-1:0];
  end

  assign si   = si_q;
  assign busy = busy_q;
  assign done = done_q;
  assign mode = mode_q;

  AST_SI_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_q) |-> !sclk); // R2
  AST_SI_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(si_q) && $past(en)) |-> $fell(sclk)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && sclk)); // R4
endmodule

// File: rtl/lsc_pix_strobe.sv
// Delays each pixel event by the settling time and emits the sample strobe.
module lsc_pix_strobe
  import lsc_pkg::*;
#(
  parameter int PIX    = 768,
  parameter int SETTLE = 16,
  parameter int IDX_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  scan_mode_e       mode,
  input  logic             busy,
  input  logic             pix_evt,
  input  logic [IDX_W-1:0] pix_num,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_idx,
  output logic [1:0]       pix_sect
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0]    CNT_LOAD = CW'(SETTLE);
  localparam logic [IDX_W-1:0] SECT_LIM = IDX_W'(PIX);

  logic             pend_q, pend_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0] num_q, num_d;
  scan_mode_e       pmode_q, pmode_d;
  logic             valid_q, valid_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       sect_q, sect_d;
  logic [1:0]       sect_calc;

  always_comb begin
    if (pmode_q == MODE_PARALLEL) sect_calc = 2'b11;
    else if (num_q < SECT_LIM)    sect_calc = 2'b01;
    else                          sect_calc = 2'b10;
  end

  always_comb begin
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    num_d   = num_q;
    pmode_d = pmode_q;
    valid_d = 1'b0;
    idx_d   = idx_q;
    sect_d  = sect_q;
    if (!en) begin
      pend_d = 1'b0;
    end else if (pix_evt) begin
      pend_d  = 1'b1;
      cnt_d   = CNT_LOAD;
      num_d   = pix_num;
      pmode_d = mode;
    end else if (pend_q) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        pend_d  = 1'b0;
        valid_d = 1'b1;
        idx_d   = num_q;
        sect_d  = sect_calc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      num_q   <= '0;
      pmode_q <= MODE_SERIAL;
      valid_q <= 1'b0;
      idx_q   <= '0;
      sect_q  <= 2'b00;
    end else begin
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      num_q   <= num_d;
      pmode_q <= pmode_d;
      valid_q <= valid_d;
      idx_q   <= idx_d;
      sect_q  <= sect_d;
    end
  end

  assign pix_valid = valid_q;
  assign pix_idx   = idx_q;
  assign pix_sect  = sect_q;

  AST_STROBE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> busy); // R6
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R6
  AST_PAR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && sect_q == 2'b11) |-> (idx_q < SECT_LIM)); // R7
endmodule

// File: rtl/linescan_timing_ctrl.sv
// Top: reset synchroniser, clock divider, scan sequencer and strobe timing.
module linescan_timing_ctrl
  import lsc_pkg::*;
#(
  parameter int PIX      = 768,
  parameter int HALF_W   = 8,
  parameter int PER_W    = 20,
  parameter int MIN_HALF = 9,
  parameter int SETTLE   = 16,
  localparam int IDX_W   = $clog2(2 * PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_parallel,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [PER_W-1:0]  cfg_period,
  output logic              sclk,
  output logic              si_a,
  output logic              hold_a,
  output logic              si_b,
  output logic              hold_b,
  output logic              busy,
  output logic              line_done,
  output logic              pix_valid,
  output logic [IDX_W-1:0]  pix_idx,
  output logic [1:0]        pix_sect
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic             rise_evt, fall_evt;
  logic             si_int, busy_int;
  scan_mode_e       mode_q;
  logic             pix_evt;
  logic [IDX_W-1:0] pix_num;

  lsc_sclk_gen #(
    .HALF_W  (HALF_W),
    .MIN_HALF(MIN_HALF)
  ) u_clk (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .en      (en),
    .cfg_half(cfg_half),
    .sclk    (sclk),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  lsc_scan_seq #(
    .PIX  (PIX),
    .PER_W(PER_W),
    .IDX_W(IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en        (en),
    .cfg_mode  (scan_mode_e'(cfg_parallel)),
    .cfg_period(cfg_period),
    .sclk      (sclk),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .si        (si_int),
    .busy      (busy_int),
    .done      (line_done),
    .mode      (mode_q),
    .pix_evt   (pix_evt),
    .pix_num   (pix_num)
  );

  lsc_pix_strobe #(
    .PIX   (PIX),
    .SETTLE(SETTLE),
    .IDX_W (IDX_W)
  ) u_stb (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .en       (en),
    .mode     (mode_q),
    .busy     (busy_int),
    .pix_evt  (pix_evt),
    .pix_num  (pix_num),
    .pix_valid(pix_valid),
    .pix_idx  (pix_idx),
    .pix_sect (pix_sect)
  );

  // hold rides with the start pulse; section B's start only in parallel scans
  assign si_a   = si_int;
  assign hold_a = si_int;
  assign hold_b = si_int;
  assign si_b   = si_int && (mode_q == MODE_PARALLEL);
  assign busy   = busy_int;

  AST_SIB_SERIAL_LOW: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy_int && mode_q == MODE_SERIAL) |-> !si_b); // R3
endmodule

// File: tb/sim_linescan_timing_ctrl.sv
module sim_linescan_timing_ctrl;
  localparam int PIX = 16, HALF_W = 8, PER_W = 12, MIN_HALF = 3, SETTLE = 4;
  localparam int IDX_W = $clog2(2 * PIX);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, en, cfg_parallel;
  logic [HALF_W-1:0] cfg_half;
  logic [PER_W-1:0]  cfg_period;
  logic sclk, si_a, hold_a, si_b, hold_b, busy, line_done, pix_valid;
  logic [IDX_W-1:0]  pix_idx;
  logic [1:0]        pix_sect;

  linescan_timing_ctrl #(.PIX(PIX), .HALF_W(HALF_W), .PER_W(PER_W),
    .MIN_HALF(MIN_HALF), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_parallel(cfg_parallel),
    .cfg_half(cfg_half), .cfg_period(cfg_period), .sclk(sclk), .si_a(si_a),
    .hold_a(hold_a), .si_b(si_b), .hold_b(hold_b), .busy(busy),
    .line_done(line_done), .pix_valid(pix_valid), .pix_idx(pix_idx),
    .pix_sect(pix_sect));

  int n_chk = 0, n_err = 0, n_done = 0;
  int exp_half = MIN_HALF;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int half_of(input int h);
    return (h < MIN_HALF) ? MIN_HALF : h;
  endfunction
  function automatic int len_of(input bit par);
    return par ? PIX + 1 : 2 * PIX + 1;
  endfunction
  function automatic int per_of(input bit par, input int p);
    return (p < len_of(par)) ? len_of(par) : p;
  endfunction

  task automatic summary_and_finish();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // ---------------- monitor ----------------
  int  prev_sclk, prev_si, phase_len, skip_phase, since_rise;
  int  edges_since, have_prev, last_per, edge_no, si_len, strobes;
  int  sc_len, sc_per, sc_par, last_done_edge;

  always @(negedge clk) begin
    if (!rst_n || !en) begin
      skip_phase = 1; have_prev = 0; edge_no = 0; since_rise = 0;
      phase_len = 0; edges_since = 0; sc_par = 0;
      prev_sclk = sclk; prev_si = si_a;
    end else begin
      since_rise++;
      if (sclk != prev_sclk) begin
        if (skip_phase == 0) chk(phase_len == exp_half, "R1", "phase length", phase_len, exp_half);
        skip_phase = 0; phase_len = 1;
      end else phase_len++;
      if (sclk && !prev_sclk) begin
        since_rise = 0;
        edges_since++;
        if (si_a) begin
          if (have_prev != 0) chk(edges_since == last_per, "R5", "start-to-start edges", edges_since, last_per);
          have_prev = 1; last_per = sc_per; edges_since = 0; edge_no = 1;
        end else edge_no++;
      end
      if (si_a && !prev_si) begin
        chk(prev_sclk == 1 && sclk == 0, "R2", "si rise with sclk fall", sclk, 0);
        sc_par = cfg_parallel; sc_len = len_of(cfg_parallel);
        sc_per = per_of(cfg_parallel, int'(cfg_period));
        si_len = 0; strobes = 0;
        chk(busy, "R4", "busy at start", busy, 1);
      end
      if (si_a) si_len++;
      if (!si_a && prev_si != 0) chk(si_len == 2 * exp_half, "R2", "si width", si_len, 2 * exp_half);
      chk(hold_a == si_a && hold_b == si_a && si_b == (si_a && sc_par != 0), "R3",
          "hold/si_b routing", {hold_a, hold_b, si_b}, {si_a, si_a, si_a && sc_par != 0});
      if (pix_valid) begin
        chk(since_rise == SETTLE, "R6", "strobe delay", since_rise, SETTLE);
        chk(int'(pix_idx) == edge_no - 1, "R7", "pixel index", pix_idx, edge_no - 1);
        chk(int'(pix_sect) == (sc_par != 0 ? 3 : ((edge_no - 1 < PIX) ? 1 : 2)), "R7",
            "section tag", pix_sect, sc_par != 0 ? 3 : ((edge_no - 1 < PIX) ? 1 : 2));
        strobes++;
      end
      if (line_done) begin
        chk(since_rise == 0 && edge_no == sc_len, "R4", "done edge", edge_no, sc_len);
        chk(strobes == sc_len - 1, "R6", "strobes per scan", strobes, sc_len - 1);
        chk(!busy, "R4", "busy at done", busy, 0);
        last_done_edge = edge_no;
        n_done++;
      end
      prev_sclk = sclk; prev_si = si_a;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_cfg(input int h, input bit par, input int per, input int scans);
    int target;
    en <= 1'b0;
    repeat (3) @(negedge clk);
    cfg_half <= HALF_W'(h); cfg_parallel <= par; cfg_period <= PER_W'(per);
    exp_half = half_of(h);
    @(negedge clk);
    en <= 1'b1;
    target = n_done + scans;
    while (n_done < target) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary_and_finish();
  end

  initial begin
    int target;
    bit quiet;
    void'($urandom(32'd4242));
    rst_n = 1'b0; en = 1'b0; cfg_parallel = 1'b0; cfg_half = '0; cfg_period = '0;
    repeat (3) @(negedge clk);
    chk({sclk, si_a, si_b, busy, line_done, pix_valid} == 6'b0, "R9", "reset outputs",
        {sclk, si_a, si_b, busy, line_done, pix_valid}, 0);
    rst_n <= 1'b1;
    repeat (4) @(negedge clk);

    run_cfg(0, 1'b0, 0, 2);    // R1 half clamp, R5 period clamp, serial
    run_cfg(5, 1'b1, 0, 2);    // parallel, clamp to PIX+1
    run_cfg(4, 1'b1, 40, 2);   // parallel, period above length
    run_cfg(3, 1'b0, 70, 2);   // serial, long period

    // R8: change mode and period while a scan runs
    run_cfg(3, 1'b0, 0, 1);
    while (!busy) @(negedge clk);
    repeat (2) @(negedge clk);
    cfg_parallel <= 1'b1; cfg_period <= PER_W'(30);
    target = n_done + 1;
    while (n_done < target) @(negedge clk);
    chk(last_done_edge == 2 * PIX + 1, "R8", "length of scan after mid-scan change",
        last_done_edge, 2 * PIX + 1);
    target = n_done + 2;
    while (n_done < target) @(negedge clk);
    chk(last_done_edge == PIX + 1, "R8", "length of following scan", last_done_edge, PIX + 1);

    // R9: disable mid-scan
    while (!pix_valid) @(negedge clk);
    en <= 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({sclk, si_a, si_b, busy, pix_valid} == 5'b0, "R9", "outputs after disable",
        {sclk, si_a, si_b, busy, pix_valid}, 0);
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk || pix_valid || line_done || busy) quiet = 1'b0;
    end
    chk(quiet, "R9", "quiet while disabled", quiet, 1);

    for (int k = 0; k < 6; k++) begin
      int h, per;
      bit par;
      h   = $urandom_range(0, 6);
      par = 1'($urandom % 2);
      per = $urandom_range(0, 3 * len_of(par));
      run_cfg(h, par, per, 2);
    end
    en <= 1'b0;
    repeat (4) @(negedge clk);
    summary_and_finish();
  end
endmodule